// File: doc/BRIEF.md
# Two-wire potentiometer slave interface

This block is the slave end of a two-wire serial bus (SCL clock, SDA data) that carries commands to a digitally controlled potentiometer. It runs on a fast system clock. It passes both bus lines through synchronizers and finds start conditions, stop conditions and SCL edges from the synchronized samples. It never clocks logic from SCL.

A transaction starts with a start condition and an address byte. The block checks the address against a fixed device-type nibble, a fixed zero bit and three pin-strapped bits. On a match it acknowledges. A command byte follows and is acknowledged. The next byte depends on the command. For a write-style command, an optional data byte follows and is acknowledged. For a read-style command, the slave shifts a byte out to the master. Received command and data bytes go to a register bank as one-cycle strobes, each carrying the byte value. SDA is open-drain: the block only ever pulls the line low, through `sda_oe_o`.

Top module: `pot_bus_slave`

## Requirements
- R1: While reset is active, and directly after it, `sda_oe_o`, `cmd_valid_o` and `data_valid_o` are 0.
- R2: Before the first start condition, SCL clocks and SDA bits have no effect: no byte is acknowledged and no strobe fires.
- R3: The address byte is matched MSB first. Bits 7..4 must be 0101. Bit 3 must equal `strap_i[2]`, bit 2 must equal `strap_i[1]`, bit 1 must be 0, and bit 0 must equal `strap_i[0]`. A matching address is acknowledged by SDA low during the ninth SCL clock.
- R4: If any address bit does not match, no acknowledge is given and no strobe fires. Further bytes are ignored until the next start condition.
- R5: `sda_oe_o` rises on the third rising `clk` edge after the SCL falling edge that ends the eighth bit. It falls on the third rising `clk` edge after the SCL falling edge that ends the ninth clock. It changes only while SCL is low.
- R6: When the command byte is acknowledged, `cmd_valid_o` is high for exactly one cycle, in the same cycle that the acknowledge drive starts. `cmd_byte_o` carries the byte and holds it until the next command strobe.
- R7: In a write transaction, a data byte after the command byte is acknowledged. `data_valid_o` pulses for one cycle with the byte on `data_byte_o`, which holds its value otherwise. A byte after the data byte is not acknowledged.
- R8: If bit 7 of the command byte is 1, the slave sends `rd_byte_i` MSB first instead of receiving a data byte. `rd_byte_i` is captured at the SCL fall that ends the command acknowledge, and the first bit is driven from that fall. Each later bit is driven from the SCL fall that ends the previous bit. SDA is released for the master's ninth clock, and no data strobe fires.
- R9: A stop condition (SDA rising while SCL is high) ends the transaction at any point. Later bytes are not acknowledged until a new start condition.
- R10: A start condition (SDA falling while SCL is high) in the middle of any byte discards the partial byte and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases the line |
| strap_i | input | 3 | Strapped address bits {A3, A2, A0} |
| rd_byte_i | input | 8 | Byte to send on a read command |
| cmd_valid_o | output | 1 | One-cycle strobe: command byte accepted |
| cmd_byte_o | output | 8 | Last accepted command byte |
| data_valid_o | output | 1 | One-cycle strobe: data byte accepted |
| data_byte_o | output | 8 | Last accepted data byte |

## Verification
The bench targets these corner cases:
- Address bytes that are wrong in only one field each: the type nibble, the fixed zero bit, and each strap bit. A comparator that skips a field would acknowledge one of them.
- Clocking before any start, and clocking after a stop. A slave that does not fall back to idle would acknowledge stray bytes or fire strobes.
- Repeated starts in the middle of the address byte and in the middle of the command byte. A bit counter that is not cleared would misalign the next address, so the acknowledge would be missing.
- Read transfers whose first bit and alternating bits differ. An off-by-one in the transmit shift would show up as wrong bits, or as SDA held low into the master's acknowledge clock.

// File: rtl/pot_bus_pkg.sv
package pot_bus_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RX    = 3'd1,
        ST_ACK   = 3'd2,
        ST_TX    = 3'd3,
        ST_TXACK = 3'd4
    } state_e;

    typedef enum logic [1:0] {
        PH_ADDR = 2'd0,
        PH_CMD  = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        state_e             state;
        phase_e             phase;
        logic [CNT_W-1:0]   bitcnt;
        logic [BYTE_W-1:0]  shreg;
        logic [BYTE_W-1:0]  txreg;
        logic [BYTE_W-1:0]  cmd;
        logic [BYTE_W-1:0]  data;
        logic               cmd_vld;
        logic               data_vld;
        logic               rd_req;
        logic               oe;
    } ctl_t;

endpackage

// File: rtl/pot_bus_sync.sv
module pot_bus_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);

    for (genvar g = 0; g < W; g++) begin : g_line
        logic [STAGES:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-1:0], line_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign cur_o[g]  = chain_q[STAGES-1];
        assign prev_o[g] = chain_q[STAGES];
    end

endmodule

// File: rtl/pot_bus_cond.sv
module pot_bus_cond (
    input  logic scl_cur_i,
    input  logic scl_prev_i,
    input  logic sda_cur_i,
    input  logic sda_prev_i,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);

    logic scl_high;

    assign scl_high   = scl_cur_i & scl_prev_i;
    assign start_o    = scl_high & sda_prev_i & ~sda_cur_i;
    assign stop_o     = scl_high & ~sda_prev_i & sda_cur_i;
    assign scl_rise_o = scl_cur_i & ~scl_prev_i;
    assign scl_fall_o = ~scl_cur_i & scl_prev_i;

endmodule

// File: rtl/pot_bus_addr_match.sv
module pot_bus_addr_match #(
    parameter logic [3:0] DEV_TYPE = 4'b0101
) (
    input  logic [7:0] addr_i,
    input  logic [2:0] strap_i,
    output logic       hit_o
);

    logic [2:0] got;
    logic       type_ok;
    logic       fixed_ok;

    assign got      = {addr_i[3], addr_i[2], addr_i[0]};
    assign type_ok  = (addr_i[7:4] == DEV_TYPE);
    assign fixed_ok = ~addr_i[1];
    assign hit_o    = type_ok & fixed_ok & (got == strap_i);

endmodule

// File: rtl/pot_bus_slave.sv
module pot_bus_slave
    import pot_bus_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_TYPE    = 4'b0101,
    parameter int         RD_FLAG_BIT = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic [2:0]  strap_i,
    input  logic [7:0]  rd_byte_i,
    output logic        cmd_valid_o,
    output logic [7:0]  cmd_byte_o,
    output logic        data_valid_o,
    output logic [7:0]  data_byte_o
);

    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

    logic [1:0] line_cur, line_prev;
    logic       start_c, stop_c, scl_rise, scl_fall;
    logic       addr_hit;
    ctl_t       d, q;

    pot_bus_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i ({scl_i, sda_i}),
        .cur_o  (line_cur),
        .prev_o (line_prev)
    );

    pot_bus_cond u_cond (
        .scl_cur_i  (line_cur[1]),
        .scl_prev_i (line_prev[1]),
        .sda_cur_i  (line_cur[0]),
        .sda_prev_i (line_prev[0]),
        .start_o    (start_c),
        .stop_o     (stop_c),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall)
    );

    pot_bus_addr_match #(
        .DEV_TYPE (DEV_TYPE)
    ) u_match (
        .addr_i  (q.shreg),
        .strap_i (strap_i),
        .hit_o   (addr_hit)
    );

    always_comb begin
        d          = q;
        d.cmd_vld  = 1'b0;
        d.data_vld = 1'b0;
        if (stop_c) begin
            d.state = ST_IDLE;
            d.oe    = 1'b0;
        end else if (start_c) begin
            d.state  = ST_RX;
            d.phase  = PH_ADDR;
            d.bitcnt = '0;
            d.oe     = 1'b0;
        end else begin
            unique case (q.state)
                ST_RX: begin
                    if (scl_rise && (q.bitcnt != LAST_RX)) begin
                        d.shreg  = {q.shreg[BYTE_W-2:0], line_cur[0]};
                        d.bitcnt = q.bitcnt + 1'b1;
                    end else if (scl_fall && (q.bitcnt == LAST_RX)) begin
                        d.bitcnt = '0;
                        unique case (q.phase)
                            PH_ADDR: begin
                                if (addr_hit) begin
                                    d.state = ST_ACK;
                                    d.oe    = 1'b1;
                                end else begin
                                    d.state = ST_IDLE;
                                end
                            end
                            PH_CMD: begin
                                d.state   = ST_ACK;
                                d.oe      = 1'b1;
                                d.cmd     = q.shreg;
                                d.cmd_vld = 1'b1;
                                d.rd_req  = q.shreg[RD_FLAG_BIT];
                            end
                            default: begin
                                d.state    = ST_ACK;
                                d.oe       = 1'b1;
                                d.data     = q.shreg;
                                d.data_vld = 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        unique case (q.phase)
                            PH_ADDR: begin
                                d.state = ST_RX;
                                d.phase = PH_CMD;
                            end
                            PH_CMD: begin
                                if (q.rd_req) begin
                                    d.state  = ST_TX;
                                    d.txreg  = rd_byte_i;
                                    d.oe     = ~rd_byte_i[BYTE_W-1];
                                    d.bitcnt = '0;
                                end else begin
                                    d.state = ST_RX;
                                    d.phase = PH_DATA;
                                end
                            end
                            default: d.state = ST_IDLE;
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.bitcnt == LAST_TX) begin
                            d.state = ST_TXACK;
                            d.oe    = 1'b0;
                        end else begin
                            d.txreg  = q.txreg << 1;
                            d.oe     = ~q.txreg[BYTE_W-2];
                            d.bitcnt = q.bitcnt + 1'b1;
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_fall) d.state = ST_IDLE;
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe_o     = q.oe;
    assign cmd_valid_o  = q.cmd_vld;
    assign cmd_byte_o   = q.cmd;
    assign data_valid_o = q.data_vld;
    assign data_byte_o  = q.data;

endmodule

// File: rtl/pot_bus_slave_chk.sv
module pot_bus_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic       cmd_valid_o,
    input logic [7:0] cmd_byte_o,
    input logic       data_valid_o,
    input logic [7:0] data_byte_o
);

    AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o); // R6

    AST_DATA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |=> !data_valid_o); // R7

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid_o && data_valid_o)); // R7

    AST_ACK_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> sda_oe_o); // R5

    AST_ACK_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |-> sda_oe_o); // R5

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_byte_o != $past(cmd_byte_o)) |-> cmd_valid_o); // R6

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_byte_o != $past(data_byte_o)) |-> data_valid_o); // R7

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_i); // R5

endmodule

bind pot_bus_slave pot_bus_slave_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_i),
    .sda_oe_o     (sda_oe_o),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_byte_o   (cmd_byte_o),
    .data_valid_o (data_valid_o),
    .data_byte_o  (data_byte_o)
);

// File: tb/pot_bus_slave_tb.sv
module pot_bus_slave_tb;

    localparam int PH  = 6;
    localparam int LAT = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n;
    logic       scl_m, sda_m, sda_line;
    logic [2:0] strap;
    logic [7:0] rd_byte;
    logic       sda_oe, cv, dv;
    logic [7:0] cmd_b, data_b;

    assign sda_line = sda_m & ~sda_oe;

    pot_bus_slave u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .strap_i      (strap),
        .rd_byte_i    (rd_byte),
        .cmd_valid_o  (cv),
        .cmd_byte_o   (cmd_b),
        .data_valid_o (dv),
        .data_byte_o  (data_b)
    );

    int total = 0;
    int bad   = 0;

    logic       ex_oe = 1'b0, ex_cv = 1'b0, ex_dv = 1'b0;
    logic [7:0] ex_cmd = 8'h00, ex_data = 8'h00;
    logic [18:0] hist[$];
    logic [18:0] e;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference timeline: expectations set at the stimulus edge appear LAT clocks later.
    always @(negedge clk) begin
        #1;
        hist.push_back({ex_oe, ex_cv, ex_dv, ex_cmd, ex_data});
        if (hist.size() > LAT) begin
            e = hist.pop_front();
            chk(sda_oe === e[18], "R5 sda drive", {31'd0, sda_oe}, {31'd0, e[18]});
            chk(cv === e[17], "R6 command strobe", {31'd0, cv}, {31'd0, e[17]});
            chk(dv === e[16], "R7 data strobe", {31'd0, dv}, {31'd0, e[16]});
            chk(cmd_b === e[15:8], "R6 command byte", {24'd0, cmd_b}, {24'd0, e[15:8]});
            chk(data_b === e[7:0], "R7 data byte", {24'd0, data_b}, {24'd0, e[7:0]});
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, input logic fall_oe, input logic pcv, input logic pdv,
                           input logic [7:0] val, output logic seen);
        @(negedge clk); sda_m = b; idle(PH);
        @(negedge clk); scl_m = 1'b1; idle(PH);
        seen = sda_line;
        @(negedge clk); scl_m = 1'b0;
        ex_oe = fall_oe; ex_cv = pcv; ex_dv = pdv;
        if (pcv) ex_cmd = val;
        if (pdv) ex_data = val;
        @(negedge clk); ex_cv = 1'b0; ex_dv = 1'b0; idle(PH);
    endtask

    task automatic scl_low();
        @(negedge clk); scl_m = 1'b0; idle(PH);
    endtask

    task automatic start_c();
        @(negedge clk); sda_m = 1'b1; idle(PH);
        @(negedge clk); scl_m = 1'b1; idle(PH);
        @(negedge clk); sda_m = 1'b0; idle(PH);
        @(negedge clk); scl_m = 1'b0; idle(PH);
    endtask

    task automatic stop_c();
        @(negedge clk); sda_m = 1'b0; idle(PH);
        @(negedge clk); scl_m = 1'b1; idle(PH);
        @(negedge clk); sda_m = 1'b1; idle(PH);
    endtask

    // kind: 0 address/ignored, 1 command, 2 data
    task automatic send_byte(input logic [7:0] b, input logic ack, input int kind,
                             input logic after_oe, input string req);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(b[i], (i == 0) ? ack : 1'b0,
                    (i == 0) && ack && (kind == 1),
                    (i == 0) && ack && (kind == 2), b, s);
        end
        clk_bit(1'b1, after_oe, 1'b0, 1'b0, 8'h00, s);
        chk(s === ~ack, req, {31'd0, s}, {31'd0, ~ack});
    endtask

    task automatic partial(input logic [7:0] v, input int n);
        logic s;
        for (int i = 0; i < n; i++) clk_bit(v[7-i], 1'b0, 1'b0, 1'b0, 8'h00, s);
    endtask

    task automatic recv_byte(input logic [7:0] exp);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, (i > 0) ? ~exp[(i > 0) ? i - 1 : 0] : 1'b0, 1'b0, 1'b0, 8'h00, s);
            chk(s === exp[i], "R8 read bit", {31'd0, s}, {31'd0, exp[i]});
        end
        clk_bit(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, s);
        chk(s === 1'b1, "R8 released for master ack", {31'd0, s}, 32'd1);
    endtask

    logic [7:0] bad_addr [5] = '{8'h49, 8'h5B, 8'h5D, 8'h51, 8'h58};

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        scl_m = 1'b1; sda_m = 1'b1; strap = 3'b101; rd_byte = 8'h00; rst_n = 1'b1;
        #1 rst_n = 1'b0;
        idle(10);
        chk(sda_oe === 1'b0 && cv === 1'b0 && dv === 1'b0, "R1 outputs in reset",
            {29'd0, sda_oe, cv, dv}, 32'd0);
        rst_n = 1'b1;
        idle(4);
        chk(sda_oe === 1'b0 && cv === 1'b0 && dv === 1'b0, "R1 outputs after reset",
            {29'd0, sda_oe, cv, dv}, 32'd0);

        // R2: traffic before any start
        scl_low();
        send_byte(8'h59, 1'b0, 0, 1'b0, "R2 no ack before start");
        send_byte(8'h15, 1'b0, 0, 1'b0, "R2 no ack before start");

        // R3 R6 R7: full write
        start_c();
        send_byte(8'h59, 1'b1, 0, 1'b0, "R3 address ack");
        send_byte(8'h15, 1'b1, 1, 1'b0, "R6 command ack");
        send_byte(8'hA7, 1'b1, 2, 1'b0, "R7 data ack");
        stop_c();

        // R7: byte after data byte ignored
        start_c();
        send_byte(8'h59, 1'b1, 0, 1'b0, "R3 address ack");
        send_byte(8'h02, 1'b1, 1, 1'b0, "R6 command ack");
        send_byte(8'h3C, 1'b1, 2, 1'b0, "R7 data ack");
        send_byte(8'hFF, 1'b0, 0, 1'b0, "R7 no ack after data byte");
        stop_c();

        // R4: each field wrong on its own
        for (int k = 0; k < 5; k++) begin
            start_c();
            send_byte(bad_addr[k], 1'b0, 0, 1'b0, "R4 address mismatch");
            send_byte(8'h15, 1'b0, 0, 1'b0, "R4 idle after mismatch");
            stop_c();
        end

        // R3: different strap value
        strap = 3'b010;
        start_c();
        send_byte(8'h54, 1'b1, 0, 1'b0, "R3 address ack other strap");
        send_byte(8'h0F, 1'b1, 1, 1'b0, "R6 command ack");
        stop_c();
        start_c();
        send_byte(8'h59, 1'b0, 0, 1'b0, "R4 old strap rejected");
        stop_c();
        strap = 3'b101;

        // R8: reads
        rd_byte = 8'hC6;
        start_c();
        send_byte(8'h59, 1'b1, 0, 1'b0, "R3 address ack");
        send_byte(8'h85, 1'b1, 1, ~rd_byte[7], "R8 read command ack");
        rd_byte = 8'h00;
        recv_byte(8'hC6);
        stop_c();
        rd_byte = 8'h3A;
        start_c();
        send_byte(8'h59, 1'b1, 0, 1'b0, "R3 address ack");
        send_byte(8'hF0, 1'b1, 1, ~rd_byte[7], "R8 read command ack");
        recv_byte(8'h3A);
        stop_c();

        // R9: stop ends the transaction
        start_c();
        send_byte(8'h59, 1'b1, 0, 1'b0, "R3 address ack");
        stop_c();
        scl_low();
        send_byte(8'h21, 1'b0, 0, 1'b0, "R9 no ack after stop");
        start_c();
        send_byte(8'h59, 1'b1, 0, 1'b0, "R3 address ack");
        send_byte(8'h11, 1'b1, 1, 1'b0, "R6 command ack");
        stop_c();
        scl_low();
        send_byte(8'h77, 1'b0, 0, 1'b0, "R9 no data ack after stop");

        // R10: repeated start inside a byte
        start_c();
        partial(8'hA0, 3);
        start_c();
        send_byte(8'h59, 1'b1, 0, 1'b0, "R10 address ack after restart");
        send_byte(8'h33, 1'b1, 1, 1'b0, "R10 command ack after restart");
        send_byte(8'h44, 1'b1, 2, 1'b0, "R10 data ack after restart");
        stop_c();
        start_c();
        send_byte(8'h59, 1'b1, 0, 1'b0, "R3 address ack");
        partial(8'h90, 4);
        start_c();
        send_byte(8'h59, 1'b1, 0, 1'b0, "R10 address ack mid command");
        send_byte(8'h66, 1'b1, 1, 1'b0, "R10 command ack mid command");
        stop_c();

        idle(10);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule